// File: doc/BRIEF.md
# Cascadable Multichannel Serial Output Framer

This block takes a set of four 22-bit two's-complement conversion results and sends them out as a burst of four 32-bit serial words. An external master supplies the bit clock and an active-low frame strobe. Each word carries one sample together with a status flag, a 3-bit device address and a 2-bit channel number. Up to eight devices can therefore share one data line, and each of the 32 channels is identified by its own 5-bit address.

When a result set arrives the block copies it into a holding register and pulls its data-ready output low. A transfer starts only after a rising edge on the cascade input. When the last bit of channel 4 has been sent, the block pulses its cascade output so that the next device in the chain takes the line. A device with no results passes the cascade token straight on.

All logic runs on the system clock `clk`. The serial clock `sclk` is sampled on that clock, and a rising `sclk` edge is taken as the first `clk` edge at which `sclk` is high after being low. The data output has a separate enable. An enable of 0 means the line is released to high impedance, and the value on `sdata` is then undefined.

Top module: `serial_word_framer`

## Requirements
- R1: After reset, `drdy_n` is 1, `sdata_oe` is 0 and `casc_out` is 0.
- R2: A `res_valid` pulse while no burst is armed latches `res_data` (channel 1 in bits 21:0 up to channel 4 in bits 87:66) and the `flag_in` level, and drives `drdy_n` to 0 at the next clock edge.
- R3: Word layout, MSB to LSB: bits 31:10 hold the sample, bit 9 holds the latched flag, bits 8:6 hold `dev_addr`, bits 5:4 hold the channel code (0 to 3 for channels 1 to 4), and bits 3:0 are 0.
- R4: A burst is 128 bits long. It sends channel 1 first and channel 4 last, and each word goes out from bit 31 down to bit 0.
- R5: A bit is presented at the same clock edge that detects a rising `sclk` while `rfs_n` is 0. `sdata` holds that bit until the next rising `sclk`, however long `sclk` stays high.
- R6: `sdata_oe` is 1 while a bit is presented. It drops to 0 at a rising `sclk` seen with `rfs_n` high at a word boundary, and the burst then continues with the next word.
- R7: A rising edge on `casc_in` while `drdy_n` is 0 arms a burst. Without arming, `sclk` and `rfs_n` activity leaves `sdata_oe` at 0.
- R8: At the first rising `sclk` after the last bit, `sdata_oe` goes to 0, `drdy_n` goes to 1, and `casc_out` is high for exactly one clock cycle.
- R9: If `rfs_n` is high at a rising `sclk` in the middle of a word, the burst is abandoned. `sdata_oe` goes to 0, no `casc_out` pulse is issued, and `drdy_n` stays 0. A new `casc_in` edge restarts the burst at channel 1 bit 31.
- R10: A `res_valid` pulse while a burst is armed is ignored: the words sent and `drdy_n` are unaffected.
- R11: A rising `casc_in` while `drdy_n` is 1 gives a one-cycle `casc_out` pulse at the next clock edge and sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | New result set available (one-cycle pulse) |
| res_data | input | 88 | Four 22-bit samples, channel 1 in the low bits |
| flag_in | input | 1 | External status flag, latched with the results |
| dev_addr | input | 3 | Device address tag |
| casc_in | input | 1 | Cascade token input, rising edge active |
| casc_out | output | 1 | Cascade token output, one-cycle pulse |
| sclk | input | 1 | Serial bit clock from the master |
| rfs_n | input | 1 | Active-low read frame strobe |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Data output enable; 0 means high impedance |
| drdy_n | output | 1 | Active-low data ready |

## Verification
Each result appears exactly one clock edge after the stimulus that causes it. Data-ready falls one edge after `res_valid`, a cascade pass-through appears one edge after `casc_in` rises, and each serial bit, enable change and end-of-burst `casc_out` appears at the first edge that sees `sclk` high. The bench changes every input just after a falling `clk` edge. It samples the outputs at the following falling edge, which is half a cycle after the edge where they are due. It samples once more a cycle later to confirm that pulses end and that bits hold while `sclk` stays high.

// File: rtl/serial_word_framer.sv
module serial_word_framer #(
  parameter int SAMPLE_W = 22,
  parameter int NUM_CH   = 4,
  parameter int WORD_W   = 32,
  parameter int DEV_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       res_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0] res_data,
  input  logic                       flag_in,
  input  logic [DEV_W-1:0]           dev_addr,
  input  logic                       casc_in,
  output logic                       casc_out,
  input  logic                       sclk,
  input  logic                       rfs_n,
  output logic                       sdata,
  output logic                       sdata_oe,
  output logic                       drdy_n
);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int RSV_W  = WORD_W - SAMPLE_W - 1 - DEV_W - CH_W;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int TOTAL  = NUM_CH * WORD_W;
  localparam int POS_W  = $clog2(TOTAL + 1);

  logic [NUM_CH*SAMPLE_W-1:0] hold;
  logic                       hold_flag;
  logic                       sclk_q, casc_q;
  logic                       armed;
  logic [POS_W-1:0]           pos;
  logic                       sd_q, oe_q, drdy_q, cout_q;

  logic              sclk_rise, casc_rise, at_end, mid_word, next_bit;
  logic [CH_W-1:0]   ch_idx;
  logic [BIT_W-1:0]  bit_idx;
  logic [WORD_W-1:0] cur_word;

  assign sclk_rise = sclk & ~sclk_q;
  assign casc_rise = casc_in & ~casc_q;
  assign ch_idx    = pos[BIT_W +: CH_W];
  assign bit_idx   = pos[BIT_W-1:0];
  assign at_end    = (pos == POS_W'(TOTAL));
  assign mid_word  = (bit_idx != '0);
  assign cur_word  = {hold[ch_idx*SAMPLE_W +: SAMPLE_W], hold_flag, dev_addr, ch_idx, {RSV_W{1'b0}}};
  assign next_bit  = cur_word[(WORD_W-1) - int'(bit_idx)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_flag <= 1'b0;
      sclk_q    <= 1'b0;
      casc_q    <= 1'b0;
      armed     <= 1'b0;
      pos       <= '0;
      sd_q      <= 1'b0;
      oe_q      <= 1'b0;
      drdy_q    <= 1'b1;
      cout_q    <= 1'b0;
    end else begin
      sclk_q <= sclk;
      casc_q <= casc_in;
      cout_q <= 1'b0;
      if (res_valid && !armed) begin
        hold      <= res_data;
        hold_flag <= flag_in;
        drdy_q    <= 1'b0;
      end
      if (casc_rise && !armed) begin
        if (!drdy_q) begin
          armed <= 1'b1;
          pos   <= '0;
        end else begin
          cout_q <= 1'b1;
        end
      end
      if (armed && sclk_rise) begin
        if (at_end) begin
          armed  <= 1'b0;
          oe_q   <= 1'b0;
          cout_q <= 1'b1;
          drdy_q <= 1'b1;
          pos    <= '0;
        end else if (!rfs_n) begin
          sd_q <= next_bit;
          oe_q <= 1'b1;
          pos  <= pos + 1'b1;
        end else if (mid_word) begin
          armed <= 1'b0;
          oe_q  <= 1'b0;
          pos   <= '0;
        end else begin
          oe_q <= 1'b0;
        end
      end
    end
  end

  assign sdata    = sd_q;
  assign sdata_oe = oe_q;
  assign drdy_n   = drdy_q;
  assign casc_out = cout_q;

  a_r7_oe_only_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> armed);
  a_r6_oe_rises_under_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> !$past(rfs_n));
  a_r8_casc_out_single: assert property (@(posedge clk) disable iff (!rst_n)
    casc_out |=> !casc_out);
  a_r8_casc_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
    casc_out |-> !armed);
  a_r10_latch_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> !$past(armed));
  a_r4_pos_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_W'(TOTAL));
endmodule

// File: tb/serial_word_framer_test.sv
module serial_word_framer_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [2:0] DEV = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0, res_valid = 1'b0, flag_in = 1'b0;
  logic [87:0] res_data = '0;
  logic casc_in = 1'b0, sclk = 1'b0, rfs_n = 1'b1;
  logic casc_out, sdata, sdata_oe, drdy_n;
  int n_run = 0, n_fail = 0;

  serial_word_framer uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .flag_in(flag_in), .dev_addr(DEV), .casc_in(casc_in), .casc_out(casc_out),
    .sclk(sclk), .rfs_n(rfs_n), .sdata(sdata), .sdata_oe(sdata_oe), .drdy_n(drdy_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [21:0] d, input logic f, input int ch);
    return {d, f, DEV, 2'(ch), 4'b0000};
  endfunction

  task automatic rise(output logic b, output logic e, output logic c);
    sclk = 1'b1;
    @(negedge clk); b = sdata; e = sdata_oe; c = casc_out;
    sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic load(input logic [87:0] d, input logic f);
    res_data = d; flag_in = f; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0;
    chk(drdy_n == 1'b0, "R2 drdy_n after res_valid", 32'(drdy_n), 0);
  endtask

  task automatic arm();
    casc_in = 1'b1; @(negedge clk);
    casc_in = 1'b0; @(negedge clk);
  endtask

  task automatic read_word(input int ch, input logic [31:0] exp, input string tag);
    logic [31:0] got; logic b, e, c; bit all_oe = 1;
    rfs_n = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      rise(b, e, c);
      got[i] = b;
      if (!e || c) all_oe = 0;
    end
    chk(got == exp, tag, got, exp);
    chk(all_oe, "R6 oe high during word", 32'(all_oe), 1);
    rfs_n = 1'b1;
  endtask

  task automatic t_reset();
    chk(drdy_n == 1'b1, "R1 drdy_n reset", 32'(drdy_n), 1);
    chk(sdata_oe == 1'b0, "R1 oe reset", 32'(sdata_oe), 0);
    chk(casc_out == 1'b0, "R1 casc_out reset", 32'(casc_out), 0);
  endtask

  task automatic t_token_pass();
    casc_in = 1'b1; @(negedge clk);
    chk(casc_out == 1'b1, "R11 token passed", 32'(casc_out), 1);
    casc_in = 1'b0; @(negedge clk);
    chk(casc_out == 1'b0, "R11 token one cycle", 32'(casc_out), 0);
    chk(sdata_oe == 1'b0, "R11 nothing sent", 32'(sdata_oe), 0);
  endtask

  task automatic t_unarmed(input logic [87:0] d);
    logic b, e, c; bit any = 0;
    load(d, 1'b1);
    rfs_n = 1'b0;
    for (int i = 0; i < 4; i++) begin rise(b, e, c); if (e) any = 1; end
    rfs_n = 1'b1;
    chk(!any, "R7 no output without arm", 32'(any), 0);
  endtask

  task automatic finish_burst();
    logic b, e, c;
    rise(b, e, c);
    chk(c == 1'b1, "R8 casc_out at end", 32'(c), 1);
    chk(e == 1'b0, "R8 oe off at end", 32'(e), 0);
    chk(drdy_n == 1'b1, "R8 drdy_n released", 32'(drdy_n), 1);
    chk(casc_out == 1'b0, "R8 casc_out one cycle", 32'(casc_out), 0);
  endtask

  task automatic t_burst(input logic [87:0] d, input logic f);
    logic b, e, c;
    arm();
    chk(sdata_oe == 1'b0, "R5 oe before first sclk", 32'(sdata_oe), 0);
    for (int ch = 0; ch < 4; ch++) begin
      read_word(ch, exp_word(d[ch*22 +: 22], f, ch), $sformatf("R3 R4 word ch%0d", ch + 1));
      if (ch < 3) begin
        rise(b, e, c);
        chk(e == 1'b0 && c == 1'b0, "R6 oe off between words", {30'b0, e, c}, 0);
      end
    end
    finish_burst();
  endtask

  task automatic t_hold_high(input logic [87:0] d, input logic f);
    logic [31:0] w;
    w = exp_word(d[21:0], f, 0);
    arm();
    rfs_n = 1'b0; sclk = 1'b1;
    @(negedge clk);
    chk(sdata == w[31] && sdata_oe, "R5 first bit on sclk rise", {30'b0, sdata_oe, sdata}, {30'b0, 1'b1, w[31]});
    @(negedge clk); @(negedge clk);
    chk(sdata == w[31], "R5 bit held while sclk high", 32'(sdata), 32'(w[31]));
    sclk = 1'b0; @(negedge clk);
    sclk = 1'b1; @(negedge clk);
    chk(sdata == w[30], "R5 second bit", 32'(sdata), 32'(w[30]));
    sclk = 1'b0; @(negedge clk);
    rfs_n = 1'b1; sclk = 1'b1; @(negedge clk);
    sclk = 1'b0; @(negedge clk);
  endtask

  task automatic t_abort(input logic [87:0] d, input logic f);
    logic b, e, c; bit any = 0;
    arm();
    rfs_n = 1'b0;
    for (int i = 0; i < 10; i++) rise(b, e, c);
    rfs_n = 1'b1;
    rise(b, e, c);
    chk(e == 1'b0, "R9 oe off on abort", 32'(e), 0);
    chk(c == 1'b0, "R9 no casc_out on abort", 32'(c), 0);
    chk(drdy_n == 1'b0, "R9 drdy_n kept", 32'(drdy_n), 0);
    rfs_n = 1'b0;
    for (int i = 0; i < 3; i++) begin rise(b, e, c); if (e) any = 1; end
    rfs_n = 1'b1;
    chk(!any, "R9 no output after abort", 32'(any), 0);
    t_burst(d, f);
  endtask

  task automatic t_ignore_load(input logic [87:0] d, input logic f, input logic [87:0] d2);
    logic b, e, c;
    arm();
    read_word(0, exp_word(d[21:0], f, 0), "R10 word ch1");
    rise(b, e, c);
    res_data = d2; flag_in = ~f; res_valid = 1'b1; @(negedge clk); res_valid = 1'b0;
    for (int ch = 1; ch < 4; ch++) begin
      read_word(ch, exp_word(d[ch*22 +: 22], f, ch), $sformatf("R10 word ch%0d unchanged", ch + 1));
      if (ch < 3) rise(b, e, c);
    end
    finish_burst();
  endtask

  localparam logic [87:0] SET_A = {22'h000001, 22'h3FFFFF, 22'h1FFFFF, 22'h200000};
  localparam logic [87:0] SET_B = {22'h30C30C, 22'h0F0F0F, 22'h2ABCDE, 22'h012345};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_token_pass();
    t_unarmed(SET_A);
    t_burst(SET_A, 1'b1);
    load(SET_B, 1'b0);
    t_hold_high(SET_B, 1'b0);
    t_abort(SET_B, 1'b0);
    load(SET_A, 1'b0);
    t_ignore_load(SET_A, 1'b0, SET_B);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule